// File: doc/BRIEF.md
# Multi-channel offset PWM generator

This block is a bank of `NUM_CH` pulse-width channels that share one clock. Each channel has three 32-bit settings, all counted in clock cycles: a period, a high-time and a phase offset. The waveform is set through a simple single-cycle register write port, and the registers are read back through a combinational read port. Setting writes land in shadow copies. A single load command moves every shadow set into the active set at once. The same load restarts every channel counter from zero, so all channels become phase-aligned at that moment.

A small load controller decides when a load takes effect. While the align-now bit is set, the load applies on the cycle after the command. While the bit is clear, the load waits until every channel has completed the period it was running. A hold bit in the control register keeps the counters at zero and all outputs low. The hold bit is set after power-on reset, so software must clear it to start the core.

Load controller states: `LD_IDLE` (no load outstanding) and `LD_PEND` (a deferred load is waiting for channels to finish their periods). Transitions: `LD_IDLE -> LD_IDLE` with an apply pulse, when a load arrives and align-now is set. `LD_IDLE -> LD_PEND` when a load arrives and align-now is clear. `LD_PEND -> LD_PEND` while at least one channel has not yet ended a period. `LD_PEND -> LD_IDLE` with an apply pulse, when every channel has ended a period or when align-now becomes set.

Top module: `pwm_bank`

## Requirements
- R1: Writes to a channel's settings (period at 0x40+4*ch, high-time at 0x80+4*ch, offset at 0xC0+4*ch, byte addresses, ch < 16) only change the shadow copy. That copy reads back at the same address. The outputs and the active settings do not change until a load is applied.
- R2: Writing 1 to bit 1 of the control register (0x10) issues a load. That bit reads 1 in the cycle after the write and reads 0 one cycle later.
- R3: Bit 0 of the control register is the hold bit, and it is 1 after power-on reset. While it is 1, every output is low.
- R4: Applying a load copies all shadow settings into the active settings and resets every channel counter to 0 on the same edge.
- R5: When bit 1 of the mode register (0x18) is 1, a load applies at the edge that follows the cycle in which the load bit reads 1.
- R6: When mode bit 1 is 0, a load applies at the first edge by which every channel has reached the last count of its period since the controller entered `LD_PEND`. Until then, the old settings keep running.
- R7: A channel whose active period is 0 keeps its output low.
- R8: With active period P > 0, the counter runs 0..P-1 and wraps. The output is high when the counter is at least the offset and below offset plus high-time.
- R9: A high-time larger than the room left in the period is clipped at P, so the output stays high to the end of the period.
- R10: A channel whose offset is greater than or equal to its period never goes high.
- R11: Address 0x0C reads 0x601A3471 and 0x14 reads `NUM_CH`. Address 0x08 is a scratch register that returns the last value written. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the counters |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| pwm_o | output | NUM_CH | One pulse output per channel |

## Verification
The waveform is tested on four channels at once, each with a different setting. One channel has an offset inside a plain period. One has a high-time longer than its period, which shows the clipping. One has a zero period, and one has an offset equal to its period. This separates the compare window from the clipping rule and from the two silent cases. A forced load and a deferred load are issued against counters that the bench tracks. In the deferred case, new settings are written to the shadows while the old waveform keeps running. The apply edge then depends on the last channel to finish its period, so applying early or late, or letting a shadow write leak through, shows up as a mismatched output vector. The hold bit, the self-clearing load bit and the identification reads are checked through the read port.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int CNT_W  = 32;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 4;

    localparam logic [REG_W-1:0]  CORE_ID     = 32'h601A3471;
    localparam logic [ADDR_W-1:0] ADR_SCRATCH = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_ID      = 8'h0C;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_NCH     = 8'h14;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 8'h18;

    localparam logic [1:0] BANK_PER = 2'b01;
    localparam logic [1:0] BANK_HI  = 2'b10;
    localparam logic [1:0] BANK_OFS = 2'b11;

    localparam int CTRL_HOLD_BIT  = 0;
    localparam int CTRL_LOAD_BIT  = 1;
    localparam int MODE_ALIGN_BIT = 1;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] offset;
    } ch_cfg_t;

    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_PEND = 1'b1
    } ld_state_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [REG_W-1:0]           rd_data,
    output ch_cfg_t [NUM_CH-1:0]       shadow_o,
    output logic                       hold_o,
    output logic                       load_o,
    output logic                       align_o
);
    logic [REG_W-1:0] scratch_q;
    logic             hold_q;
    logic             load_q;
    logic             align_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q <= '0;
            hold_q    <= 1'b1;
            load_q    <= 1'b0;
            align_q   <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (wr_en) begin
                if (wr_addr == ADR_SCRATCH) scratch_q <= wr_data;
                if (wr_addr == ADR_CTRL) begin
                    hold_q <= wr_data[CTRL_HOLD_BIT];
                    load_q <= wr_data[CTRL_LOAD_BIT];
                end
                if (wr_addr == ADR_MODE) align_q <= wr_data[MODE_ALIGN_BIT];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
        logic slot_hit;
        assign slot_hit = wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr[5:2] == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_o[g] <= '0;
            end else if (slot_hit) begin
                unique case (wr_addr[7:6])
                    BANK_PER: shadow_o[g].period <= wr_data;
                    BANK_HI:  shadow_o[g].high   <= wr_data;
                    BANK_OFS: shadow_o[g].offset <= wr_data;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_SCRATCH: rd_data = scratch_q;
            ADR_ID:      rd_data = CORE_ID;
            ADR_CTRL:    rd_data = {{(REG_W-2){1'b0}}, load_q, hold_q};
            ADR_NCH:     rd_data = REG_W'(NUM_CH);
            ADR_MODE:    rd_data = {{(REG_W-2){1'b0}}, align_q, 1'b0};
            default:     ;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if ((rd_addr[1:0] == 2'b00) && (rd_addr[5:2] == IDX_W'(c))) begin
                case (rd_addr[7:6])
                    BANK_PER: rd_data = shadow_o[c].period;
                    BANK_HI:  rd_data = shadow_o[c].high;
                    BANK_OFS: rd_data = shadow_o[c].offset;
                    default:  ;
                endcase
            end
        end
    end

    assign hold_o  = hold_q;
    assign load_o  = load_q;
    assign align_o = align_q;
endmodule

// File: rtl/pwm_bank_loadctl.sv
module pwm_bank_loadctl
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              align_now,
    input  logic [NUM_CH-1:0] wrap_i,
    output logic              apply_o
);
    ld_state_t         state_q, state_d;
    logic [NUM_CH-1:0] done_q;
    logic              all_done;

    assign all_done = &(done_q | wrap_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  done_q <= '0;
        else if (state_q == LD_PEND) done_q <= done_q | wrap_i;
        else                         done_q <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (load_req && !align_now) state_d = LD_PEND;
            LD_PEND: if (align_now || all_done)  state_d = LD_IDLE;
            default: state_d = LD_IDLE;
        endcase
    end

    always_comb begin
        apply_o = 1'b0;
        unique case (state_q)
            LD_IDLE: apply_o = load_req && align_now;
            LD_PEND: apply_o = align_now || all_done;
            default: apply_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold,
    input  logic    restart,
    input  ch_cfg_t cfg,
    output logic    wrap_o,
    output logic    pwm_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             off_q;
    logic [CNT_W:0]   hi_end;
    logic [CNT_W:0]   limit;

    assign off_q  = (cfg.period == '0);
    assign wrap_o = off_q || (cnt_q == cfg.period - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (hold || restart || off_q)    cnt_q <= '0;
        else if (cnt_q == cfg.period - CNT_W'(1)) cnt_q <= '0;
        else                                  cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        hi_end = {1'b0, cfg.offset} + {1'b0, cfg.high};
        limit  = (hi_end > {1'b0, cfg.period}) ? {1'b0, cfg.period} : hi_end;
        pwm_o  = !off_q && !hold && (cnt_q >= cfg.offset) && ({1'b0, cnt_q} < limit);
    end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [NUM_CH-1:0] pwm_o
);
    ch_cfg_t [NUM_CH-1:0] shadow_cfg;
    ch_cfg_t [NUM_CH-1:0] act_cfg;
    logic                 core_hold;
    logic                 load_req;
    logic                 align_now;
    logic                 apply;
    logic [NUM_CH-1:0]    wrap_vec;

    pwm_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .shadow_o (shadow_cfg),
        .hold_o   (core_hold),
        .load_o   (load_req),
        .align_o  (align_now)
    );

    pwm_bank_loadctl #(.NUM_CH(NUM_CH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .align_now (align_now),
        .wrap_i    (wrap_vec),
        .apply_o   (apply)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     act_cfg[g] <= '0;
            else if (apply) act_cfg[g] <= shadow_cfg[g];
        end

        pwm_bank_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (core_hold),
            .restart (apply),
            .cfg     (act_cfg[g]),
            .wrap_o  (wrap_vec[g]),
            .pwm_o   (pwm_o[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 core_hold,
    input logic                 load_req,
    input logic                 align_now,
    input logic                 apply,
    input ch_cfg_t [NUM_CH-1:0] shadow_cfg,
    input ch_cfg_t [NUM_CH-1:0] act_cfg,
    input logic [NUM_CH-1:0]    pwm_o
);
    assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> (pwm_o == '0)) else $error("hold bit set but an output is high");

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !wr_en) |=> !load_req) else $error("load bit did not self-clear");

    assert_force_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && align_now) |-> apply) else $error("aligned load not applied");

    assert_apply_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (act_cfg == $past(shadow_cfg))) else $error("apply did not copy shadows");

    assert_active_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_cfg)) else $error("active settings changed without a load");

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_zero_period_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cfg[g].period == '0) |-> !pwm_o[g]) else $error("zero-period channel high");

        assert_late_offset_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cfg[g].offset >= act_cfg[g].period) |-> !pwm_o[g]) else $error("offset past period but high");
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .core_hold  (core_hold),
    .load_req   (load_req),
    .align_now  (align_now),
    .apply      (apply),
    .shadow_cfg (shadow_cfg),
    .act_cfg    (act_cfg),
    .pwm_o      (pwm_o)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [7:0]     rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pwm_o;

    pwm_bank #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [NCH-1:0] v;
        string          tag;
    } item_t;

    item_t       sb_q[$];
    item_t       mon_it;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          track = 1'b0;
    bit          finished = 1'b0;
    int          kk = 0;
    string       cur_tag = "R1";
    int unsigned eP[NCH];
    int unsigned eH[NCH];
    int unsigned eO[NCH];

    function automatic logic exp_bit(int k, int unsigned p, int unsigned h, int unsigned o);
        longint unsigned e;
        int unsigned     c;
        if (p == 0) return 1'b0;
        if (o >= p) return 1'b0;
        c = k % p;
        e = longint'(o) + longint'(h);
        if (e > p) e = p;
        return (c >= o) && (longint'(c) < e);
    endfunction

    task automatic tick();
        if (track) begin
            item_t it;
            for (int c = 0; c < NCH; c++) it.v[c] = exp_bit(kk, eP[c], eH[c], eO[c]);
            it.tag = cur_tag;
            sb_q.push_back(it);
        end
        @(posedge clk);
        #1;
        kk++;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            n_vec++;
            if (pwm_o !== mon_it.v) begin
                n_bad++;
                $display("FAIL %s pwm_o actual=%b expected=%b", mon_it.tag, pwm_o, mon_it.v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin eP[c] = 0; eH[c] = 0; eO[c] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // reset state and identification (R3, R11)
        chk("R3 reset outputs", 32'(pwm_o), 32'h0);
        rd_chk("R3 hold bit after reset", 8'h10, 32'h1);
        rd_chk("R11 id", 8'h0C, 32'h601A3471);
        rd_chk("R11 channel count", 8'h14, 32'd4);
        rd_chk("R11 unmapped 0x20", 8'h20, 32'h0);
        rd_chk("R11 unmapped 0x3C", 8'h3C, 32'h0);
        wr(8'h08, 32'hA5C3_0F11);
        rd_chk("R11 scratch", 8'h08, 32'hA5C3_0F11);

        // shadow writes, nothing active yet (R1)
        track = 1'b1; cur_tag = "R1";
        wr(8'h40, 32'd8); wr(8'h80, 32'd3); wr(8'hC0, 32'd2);
        wr(8'h44, 32'd5); wr(8'h84, 32'd9); wr(8'hC4, 32'd1);
        wr(8'h48, 32'd0); wr(8'h88, 32'd2); wr(8'hC8, 32'd0);
        wr(8'h4C, 32'd6); wr(8'h8C, 32'd2); wr(8'hCC, 32'd6);
        rd_chk("R1 shadow period ch0", 8'h40, 32'd8);
        rd_chk("R1 shadow high ch1", 8'h84, 32'd9);
        wr(8'h18, 32'h2);
        wr(8'h10, 32'h0);
        tick(); tick();

        // forced load (R2, R4, R5)
        rd_addr = 8'h10;
        wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h2;
        tick();
        wr_en = 1'b0;
        #1 chk("R2 load bit set", rd_data, 32'h2);
        tick();
        kk = 0;
        eP[0] = 8; eH[0] = 3; eO[0] = 2;
        eP[1] = 5; eH[1] = 9; eO[1] = 1;
        eP[2] = 0; eH[2] = 2; eO[2] = 0;
        eP[3] = 6; eH[3] = 2; eO[3] = 6;
        rd_chk("R2 load bit cleared", 8'h10, 32'h0);
        cur_tag = "R4 R5 R7 R8 R9 R10";
        repeat (24) tick();

        // deferred load with shadow writes under a running waveform (R1, R6)
        cur_tag = "R1 R6";
        wr(8'h18, 32'h0);
        wr(8'h40, 32'd4); wr(8'h80, 32'd3); wr(8'hC0, 32'd1);
        wr(8'h10, 32'h2);
        tick();
        while (kk <= 35) tick();
        kk = 0;
        eP[0] = 4; eH[0] = 3; eO[0] = 1;
        cur_tag = "R4 R6 R8";
        repeat (16) tick();

        // hold bit forces outputs low (R3)
        track = 1'b0;
        wr(8'h10, 32'h1);
        for (int i = 0; i < 4; i++) begin
            chk("R3 outputs low under hold", 32'(pwm_o), 32'h0);
            tick();
        end
        rd_chk("R3 hold bit reads back", 8'h10, 32'h1);

        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule